// File: doc/BRIEF.md
# Page-Buffered Write Commit Controller

This block sits behind a serial memory bus front-end and turns a write transfer into a single committed update of a 4K x 8 storage array. The front-end reports three events. The first is an address load, which carries the 12-bit word address. The second is one strobe per received data byte. The third is the end-of-transfer (Stop) event. Bytes collect in a 32-entry page buffer. The buffer slot is chosen by the low five bits of the write pointer, and that 5-bit field wraps, so a long transfer overwrites its own earlier bytes instead of spilling into the next page.

At Stop, the block decides whether the buffered bytes are written. It samples a write-protect input at that moment. When protection is active and the page lies in the top quarter of the array (0xC00 to 0xFFF), the buffered bytes are dropped and no busy period follows. In every other case, a Stop that finds at least one loaded slot starts an internal write cycle. During that cycle, the controller copies each loaded slot into the array and holds `busy` high for a fixed, parameterised number of clocks. The front-end uses `busy` to withhold acknowledges. A registered read port on the array lets the surrounding logic observe the stored contents.

Top module: `page_commit_ctrl`

## Requirements
- R1: A byte strobe, taken while idle and without an address load in the same cycle, stores the byte in the slot given by `wr_ptr[4:0]`. It then increments only `wr_ptr[4:0]`, modulo 32, and leaves `wr_ptr[11:5]` unchanged.
- R2: When more than 32 bytes arrive before Stop, the slot index wraps to 0. Later bytes replace the earlier bytes in the same slots, and no location outside the addressed page is written.
- R3: The array is never written before a Stop event. A write cycle starts only on a Stop taken while idle.
- R4: After a Stop that starts a write cycle, `busy` rises on the next clock edge and stays high for exactly BUSY_CYCLES cycles.
- R5: A write cycle writes only the slots loaded since the last address load. The other locations of the page keep their contents.
- R6: When a Stop finds `wp` high and the page inside 0xC00 to 0xFFF, the array is not written and `busy` stays low. A new command is accepted in the next cycle.
- R7: A high `wp` has no effect when the page lies below 0xC00.
- R8: `wp` is sampled only in the Stop cycle. Changing it during the write cycle does not cancel the write.
- R9: After a write, `wr_ptr` holds the address that follows the last byte written, wrapped within the page.
- R10: A Stop with no byte received since the last address load starts no write cycle.
- R11: Address loads, byte strobes and Stop events that arrive while `busy` is high are ignored. `wr_ptr` holds its value, and no second write cycle follows.
- R12: After reset, `busy` is 0 and `wr_ptr` is 0.
- R13: An address load discards any bytes buffered since the previous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | One-cycle pulse: load `addr_in` into the pointer |
| addr_in | input | 12 | Word address carried with `addr_load` |
| byte_stb | input | 1 | One-cycle pulse: `byte_in` is a received data byte |
| byte_in | input | 8 | Data byte |
| stop_evt | input | 1 | One-cycle pulse: end of the write transfer |
| wp | input | 1 | Write-protect level, sampled at Stop |
| busy | output | 1 | Internal write cycle in progress |
| wr_ptr | output | 12 | Current write pointer |
| peek_addr | input | 12 | Array read address |
| peek_data | output | 8 | Array data at `peek_addr`, one cycle later |

## Verification
The bench keeps the 32-byte page and the 0xC00 protection boundary at their default values. It shortens BUSY_CYCLES to 36, which is just above the 33 cycles that a full-page copy needs. This keeps every write cycle short, so each test case can run several commits. It also means the copy pipeline has its last write only a few cycles before `busy` falls, and that is the timing case for R4 and R5. With a 34-byte transfer that starts two slots before the page end, the bench covers both the slot wrap and the check that no write crosses the page boundary.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // Bus event accepted in a given cycle; load outranks byte, byte outranks stop.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LOAD = 2'd1,
    EV_BYTE = 2'd2,
    EV_STOP = 2'd3
  } bus_ev_t;
endpackage

// File: rtl/pcc_page_buf.sv
module pcc_page_buf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic [IDX_W-1:0]  rd_idx_q,
  output logic              any_valid
);
  logic [DATA_W-1:0]     slots [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;

  // storage: plain RAM, one write and one registered read
  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
    rd_data <= slots[rd_idx];
  end

  // per-slot loaded flags
  always_ff @(posedge clk) begin
    if (rst || clr) loaded <= '0;
    else if (wr_en) loaded[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld   <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      rd_vld   <= rd_en && loaded[rd_idx];
      rd_idx_q <= rd_idx;
    end
  end

  assign any_valid = |loaded;
endmodule

// File: rtl/pcc_commit_seq.sv
module pcc_commit_seq #(
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 48,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLOTS = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rd_en  = busy && (cnt < SLOTS);
  assign rd_idx = cnt[IDX_W-1:0];
  assign done   = busy && (cnt == LAST);
endmodule

// File: rtl/pcc_array.sv
module pcc_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 48,
  parameter logic [ADDR_W-1:0] PROT_LO = 12'hC00,
  parameter logic [ADDR_W-1:0] PROT_HI = 12'hFFF,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_evt,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  bus_ev_t           ev;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] page_base;
  logic              prot_hit;
  logic              any_valid;
  logic              seq_start;
  logic              seq_done;
  logic              buf_clr;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  rd_idx_q;
  logic [DATA_W-1:0] rd_data;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;

  // event decode; nothing is taken during a write cycle
  always_comb begin
    ev = EV_NONE;
    if (!busy) begin
      if (addr_load)     ev = EV_LOAD;
      else if (byte_stb) ev = EV_BYTE;
      else if (stop_evt) ev = EV_STOP;
    end
  end

  // pointer: load whole, advance low field only
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (ev == EV_LOAD) begin
      ptr_q <= addr_in;
    end else if (ev == EV_BYTE) begin
      ptr_q <= {ptr_q[ADDR_W-1:IDX_W], ptr_q[IDX_W-1:0] + 1'b1};
    end
  end

  assign page_base = {ptr_q[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  assign prot_hit  = wp && (page_base >= PROT_LO) && (page_base <= PROT_HI);
  assign seq_start = (ev == EV_STOP) && any_valid && !prot_hit;
  assign buf_clr   = (ev == EV_LOAD) || seq_done ||
                     ((ev == EV_STOP) && prot_hit);

  pcc_page_buf #(
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ev == EV_BYTE),
    .wr_idx   (ptr_q[IDX_W-1:0]),
    .wr_data  (byte_in),
    .clr      (buf_clr),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_vld   (arr_we),
    .rd_idx_q (rd_idx_q),
    .any_valid(any_valid)
  );

  pcc_commit_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (seq_start),
    .busy  (busy),
    .rd_en (rd_en),
    .rd_idx(rd_idx),
    .done  (seq_done)
  );

  // page bits are frozen while busy, so they address the copy directly
  assign arr_waddr = {ptr_q[ADDR_W-1:IDX_W], rd_idx_q};

  pcc_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_arr (
    .clk  (clk),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(rd_data),
    .raddr(peek_addr),
    .rdata(peek_data)
  );

  assign wr_ptr = ptr_q;

  initial begin
    if (BUSY_CYCLES < PAGE_BYTES + 1)
      $error("BUSY_CYCLES must cover the page copy");
    if (PG_W < 1)
      $error("address narrower than a page");
  end
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 48,
  parameter logic [ADDR_W-1:0] PROT_LO = 12'hC00,
  localparam int IDX_W      = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_load,
  input logic              byte_stb,
  input logic              stop_evt,
  input logic              wp,
  input logic              busy,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              any_valid,
  input logic              arr_we
);
  logic [15:0]      run_len;
  logic [IDX_W-1:0] lo_next;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else     run_len <= busy ? run_len + 1'b1 : '0;
  end

  assign lo_next = wr_ptr[IDX_W-1:0] + 1'b1;

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && byte_stb && !addr_load) |=>
      (wr_ptr[ADDR_W-1:IDX_W] == $past(wr_ptr[ADDR_W-1:IDX_W])) &&
      (wr_ptr[IDX_W-1:0] == $past(lo_next)));

  // R3
  start_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 16'(BUSY_CYCLES)));

  // R5
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R6
  prot_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !busy && !addr_load && !byte_stb && wp &&
     ({wr_ptr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}} >= PROT_LO)) |=> !busy);

  // R10
  empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && !busy && !any_valid) |=> !busy);

  // R11
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wr_ptr));
endmodule

bind page_commit_ctrl pcc_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .BUSY_CYCLES(BUSY_CYCLES),
  .PROT_LO    (PROT_LO)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr_load(addr_load),
  .byte_stb (byte_stb),
  .stop_evt (stop_evt),
  .wp       (wp),
  .busy     (busy),
  .wr_ptr   (wr_ptr),
  .any_valid(any_valid),
  .arr_we   (arr_we)
);

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;
  localparam int BUSY = 36;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_load = 1'b0;
  logic [11:0] addr_in = '0;
  logic        byte_stb = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        stop_evt = 1'b0;
  logic        wp = 1'b0;
  logic        busy;
  logic [11:0] wr_ptr;
  logic [11:0] peek_addr = '0;
  logic [7:0]  peek_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  page_commit_ctrl #(.BUSY_CYCLES(BUSY)) u_page_commit_ctrl (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_stb(byte_stb), .byte_in(byte_in), .stop_evt(stop_evt), .wp(wp),
    .busy(busy), .wr_ptr(wr_ptr), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [11:0] a);
    addr_in = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_byte(logic [7:0] d);
    byte_in = d; byte_stb = 1'b1;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic do_stop();
    stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic peek(logic [11:0] a, output logic [7:0] d);
    peek_addr = a;
    @(negedge clk);
    d = peek_data;
  endtask

  task automatic t_reset();
    check("R12 busy", busy, 0);
    check("R12 ptr", wr_ptr, 0);
  endtask

  task automatic t_byte_write();
    logic [7:0] d;
    int n;
    do_load(12'h123);
    do_byte(8'hA5);
    check("R1 ptr step", wr_ptr, 12'h124);
    peek(12'h123, d);
    check("R3 no write before stop", d, 0);
    do_stop();
    check("R4 busy rises", busy, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R4 busy length", n, BUSY);
    peek(12'h123, d);
    check("R5 byte stored", d, 8'hA5);
    peek(12'h124, d);
    check("R5 neighbour kept", d, 0);
    check("R9 ptr after write", wr_ptr, 12'h124);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    do_load(12'h05E);
    for (int i = 0; i < 34; i++) do_byte(8'(i + 1));
    check("R2 ptr wrapped in page", wr_ptr, 12'h040);
    do_stop();
    wait_idle();
    peek(12'h05E, d); check("R2 slot 30 overwritten", d, 33);
    peek(12'h05F, d); check("R2 slot 31 overwritten", d, 34);
    peek(12'h040, d); check("R2 slot 0", d, 3);
    peek(12'h05D, d); check("R2 slot 29", d, 32);
    peek(12'h060, d); check("R2 next page untouched", d, 0);
    check("R9 ptr after wrap", wr_ptr, 12'h040);
  endtask

  task automatic t_partial();
    logic [7:0] d;
    do_load(12'h208);
    for (int i = 0; i < 3; i++) do_byte(8'(8'h90 + i));
    do_stop();
    wait_idle();
    peek(12'h207, d); check("R5 below range kept", d, 0);
    peek(12'h20A, d); check("R5 last loaded slot", d, 8'h92);
    peek(12'h20B, d); check("R5 above range kept", d, 0);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wp = 1'b1;
    do_load(12'hC10);
    do_byte(8'h77);
    do_stop();
    check("R6 protected no busy", busy, 0);
    peek(12'hC10, d); check("R6 protected not written", d, 0);
    do_load(12'hBFF);
    do_byte(8'h11);
    do_stop();
    check("R6 new command accepted", busy, 1);
    wait_idle();
    peek(12'hBFF, d); check("R7 wp outside range", d, 8'h11);
    wp = 1'b0;
  endtask

  task automatic t_wp_after();
    logic [7:0] d;
    do_load(12'hD00);
    do_byte(8'h22);
    do_stop();
    wp = 1'b1;
    wait_idle();
    wp = 1'b0;
    peek(12'hD00, d); check("R8 wp after stop ignored", d, 8'h22);
  endtask

  task automatic t_empty_stop();
    do_load(12'h400);
    do_stop();
    check("R10 empty stop no busy", busy, 0);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    do_load(12'h500);
    do_byte(8'h33);
    do_stop();
    do_load(12'h600);
    do_byte(8'h44);
    do_stop();
    check("R11 ptr frozen", wr_ptr, 12'h501);
    wait_idle();
    @(negedge clk);
    check("R11 no second cycle", busy, 0);
    peek(12'h600, d); check("R11 ignored byte", d, 0);
    peek(12'h500, d); check("R11 first write", d, 8'h33);
  endtask

  task automatic t_reload();
    logic [7:0] d;
    do_load(12'h700);
    do_byte(8'h55);
    do_load(12'h710);
    do_byte(8'h66);
    do_stop();
    wait_idle();
    peek(12'h700, d); check("R13 discarded byte", d, 0);
    peek(12'h710, d); check("R13 kept byte", d, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_wrap();
    t_partial();
    t_protect();
    t_wp_after();
    t_empty_stop();
    t_busy_ignore();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule